// File: doc/BRIEF.md
# History-Indexed Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of two-bit saturating counters arranged as rows and columns. The low bits of the branch address pick the row. A shift register holding the most recent global branch outcomes picks the column. Two branches at the same address can therefore learn different behaviour depending on the path that led to them.

The fetch side presents an address on the lookup port and receives a taken / not-taken guess in the same cycle. When the branch later resolves, the execute side presents the same address and the real outcome on the update port. On that clock edge the block does two things: it moves the selected counter one step toward the outcome, and it shifts the outcome into the history register. The column used for the update is the history value before that shift. This is the same column that a lookup made just before the update would have used.

Top module: `bp_hist_predictor`

## Requirements
- R1: A valid update with outcome taken (`upd_taken`=1) raises the selected counter by one step, and a counter already at 11 stays at 11.
- R2: A valid update with outcome not taken raises nothing and lowers the selected counter by one step, and a counter already at 00 stays at 00.
- R3: `lk_taken` equals bit 1 of the selected counter, so states 00 and 01 give 0 (not taken) and states 10 and 11 give 1 (taken). It follows `lk_pc` combinationally in the same cycle.
- R4: While `rst_n` is low at a clock edge, every counter is set to 01 and the history register to all zeros, and any update presented then is discarded. After reset every lookup therefore gives 0.
- R5: The row is `lk_pc[ROW_W-1:0]` (default: the three least significant address bits). Address bits above these have no effect on the prediction.
- R6: The history register is `HIST_W` bits wide (default 2, giving 4 columns). On each valid update it shifts left and takes the new outcome into bit 0 (1 = taken). Its value is the column number, and the table entry is row * 2^HIST_W + history.
- R7: An update writes the entry given by `upd_pc[ROW_W-1:0]` and the history value from before its own shift. The new counter value is seen by lookups from the next cycle onward.
- R8: When `upd_valid` is low, neither the counters nor the history register change, whatever `upd_pc` and `upd_taken` hold.
- R9: A valid update changes only the one selected counter; all other counters keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | PC_W | Address of the branch being fetched |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A branch has resolved this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The assertions assume the update inputs are at known levels whenever reset is released. They also assume that a lookup and an update whose row bits match are meant to see the same column, which holds only because both read the same unshifted history register. The bench drives inputs only between clock edges, holds `upd_valid` low outside the cycles it intends as updates, and checks every row against its own counter model after each step. In the mixed phase it drives pseudo-random outcomes through a single row, so the column changes under the bench's control and the paths through history are reached.

// File: rtl/bp_pkg.sv
`timescale 1ns/1ps
// Package: shared counter encoding and step functions for the branch predictor.
// Assumes a two-bit counter where bit 1 carries the predicted direction.
package bp_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_t;

    localparam ctr_t CTR_RESET = CTR_WEAK_NT;

    // Move a counter one step toward the observed outcome, saturating at both ends.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        if (taken) begin
            nxt = (cur == CTR_STRONG_T) ? CTR_STRONG_T : ctr_t'(cur + 2'd1);
        end else begin
            nxt = (cur == CTR_STRONG_NT) ? CTR_STRONG_NT : ctr_t'(cur - 2'd1);
        end
        return nxt;
    endfunction

    // Direction implied by a counter state.
    function automatic logic ctr_dir(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/bp_hist_reg.sv
`timescale 1ns/1ps
// Module: global outcome history shift register.
// Shifts left on each enable, newest outcome entering bit 0.
// Assumes shift_en is only asserted for resolved branches.
module bp_hist_reg #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist_o
);

    logic [HIST_W-1:0] hist_q;
    logic [HIST_W:0]   widened;

    // Append the new outcome below the existing history.
    always_comb begin
        widened = {hist_q, bit_in};
    end

    // Hold or shift the history; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= widened[HIST_W-1:0];
        end
    end

    assign hist_o = hist_q;

endmodule

// File: rtl/bp_index.sv
`timescale 1ns/1ps
// Module: forms a table entry number from an address and a history value.
// Entry = row * 2^HIST_W + history; the row is the low ROW_W address bits.
module bp_index #(
    parameter int PC_W   = 32,
    parameter int ROW_W  = 3,
    parameter int HIST_W = 2,
    localparam int IDX_W = ROW_W + HIST_W
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);

    logic [ROW_W-1:0] row;

    // Take only the row bits; higher address bits are discarded.
    always_comb begin
        row = pc[ROW_W-1:0];
        idx = {row, hist};
    end

endmodule

// File: rtl/bp_ctr_cell.sv
`timescale 1ns/1ps
// Module: one two-bit saturating direction counter.
// Steps toward the outcome when written; resets to weakly not taken.
module bp_ctr_cell
    import bp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       taken,
    output logic [1:0] state_o
);

    ctr_t state_q;

    // Update the counter on a write; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTR_RESET;
        end else if (wr_en) begin
            state_q <= ctr_step(state_q, taken);
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/bp_hist_predictor.sv
`timescale 1ns/1ps
// Module: history-indexed two-bit branch direction predictor (top).
// Lookup is combinational from the counter table; update writes one counter
// at the entry chosen by the update address and the pre-shift history, and
// shifts the outcome into the history. Assumes ROW_W >= 1 and HIST_W >= 1.
module bp_hist_predictor #(
    parameter int PC_W   = 32,
    parameter int ROW_W  = 3,
    parameter int HIST_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);

    localparam int IDX_W   = ROW_W + HIST_W;
    localparam int ENTRIES = 1 << IDX_W;

    logic [HIST_W-1:0]      hist;
    logic [IDX_W-1:0]       lk_idx;
    logic [IDX_W-1:0]       upd_idx;
    logic [ENTRIES-1:0][1:0] cnt_q;
    logic [ENTRIES-1:0]     wr_sel;

    bp_hist_reg #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_valid),
        .bit_in   (upd_taken),
        .hist_o   (hist)
    );

    bp_index #(.PC_W(PC_W), .ROW_W(ROW_W), .HIST_W(HIST_W)) u_lk_index (
        .pc   (lk_pc),
        .hist (hist),
        .idx  (lk_idx)
    );

    bp_index #(.PC_W(PC_W), .ROW_W(ROW_W), .HIST_W(HIST_W)) u_upd_index (
        .pc   (upd_pc),
        .hist (hist),
        .idx  (upd_idx)
    );

    // Decode the update entry into one write strobe per counter.
    always_comb begin
        wr_sel = '0;
        if (upd_valid) begin
            wr_sel[upd_idx] = 1'b1;
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cell
        bp_ctr_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_sel[e]),
            .taken   (upd_taken),
            .state_o (cnt_q[e])
        );
    end

    // Read the direction bit of the selected counter.
    always_comb begin
        lk_taken = bp_pkg::ctr_dir(bp_pkg::ctr_t'(cnt_q[lk_idx]));
    end

endmodule

// File: rtl/bp_hist_predictor_chk.sv
`timescale 1ns/1ps
// Module: property checker bound to the predictor top.
// Observes the history register, both entry numbers and the counter table.
module bp_hist_predictor_chk #(
    parameter int PC_W   = 32,
    parameter int ROW_W  = 3,
    parameter int HIST_W = 2,
    localparam int IDX_W   = ROW_W + HIST_W,
    localparam int ENTRIES = 1 << IDX_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [PC_W-1:0]         lk_pc,
    input logic                    lk_taken,
    input logic                    upd_valid,
    input logic [PC_W-1:0]         upd_pc,
    input logic                    upd_taken,
    input logic [HIST_W-1:0]       hist,
    input logic [IDX_W-1:0]        lk_idx,
    input logic [IDX_W-1:0]        upd_idx,
    input logic [ENTRIES-1:0][1:0] cnt_q
);

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> hist == HIST_W'({$past(hist), $past(upd_taken)})); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> ($stable(hist) && $stable(cnt_q))); // R8

    AST_SAME_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_pc[ROW_W-1:0] == upd_pc[ROW_W-1:0]) |-> (lk_idx == upd_idx)); // R7

    AST_TOP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && cnt_q[upd_idx] == 2'b11)
        |=> cnt_q[$past(upd_idx)] == 2'b11); // R1

    AST_BOTTOM_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && cnt_q[upd_idx] == 2'b00)
        |=> cnt_q[$past(upd_idx)] == 2'b00); // R2

    AST_DIR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_taken == cnt_q[lk_idx][1]); // R3

    AST_ONE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> $countones(cnt_q ^ $past(cnt_q)) <= 2); // R9

endmodule

bind bp_hist_predictor bp_hist_predictor_chk #(
    .PC_W(PC_W), .ROW_W(ROW_W), .HIST_W(HIST_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_pc     (lk_pc),
    .lk_taken  (lk_taken),
    .upd_valid (upd_valid),
    .upd_pc    (upd_pc),
    .upd_taken (upd_taken),
    .hist      (hist),
    .lk_idx    (lk_idx),
    .upd_idx   (upd_idx),
    .cnt_q     (cnt_q)
);

// File: tb/bp_hist_predictor_bench.sv
`timescale 1ns/1ps
// Bench: drives update sequences and sweeps every row after each step,
// comparing the prediction with a counter model computed in the bench.
module bp_hist_predictor_bench;

    localparam int PC_W   = 32;
    localparam int ROW_W  = 3;
    localparam int HIST_W = 2;
    localparam int ROWS   = 1 << ROW_W;
    localparam int COLS   = 1 << HIST_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_taken;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    int checks = 0;
    int failures = 0;
    logic [31:0] lfsr = 32'hACE1_1234;
    int m_ctr [ROWS][COLS];
    int m_hist = 0;

    bp_hist_predictor #(.PC_W(PC_W), .ROW_W(ROW_W), .HIST_W(HIST_W)) u_bp_hist_predictor (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_pc     (lk_pc),
        .lk_taken  (lk_taken),
        .upd_valid (upd_valid),
        .upd_pc    (upd_pc),
        .upd_taken (upd_taken)
    );

    always #2 clk = ~clk;

    task automatic step_lfsr();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    task automatic model_reset();
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) m_ctr[r][c] = 1;
        m_hist = 0;
    endtask

    // Compare every row at the current history; upper address bits are scrambled (R5).
    task automatic sweep(input string tag);
        for (int r = 0; r < ROWS; r++) begin
            step_lfsr();
            lk_pc = {lfsr[PC_W-1:ROW_W], 3'(r)};
            #0.2;
            checks++;
            if (lk_taken !== ((m_ctr[r][m_hist] >= 2) ? 1'b1 : 1'b0)) begin
                failures++;
                $display("FAIL %s row=%0d hist=%0d actual=%b expected=%b", tag, r, m_hist,
                         lk_taken, (m_ctr[r][m_hist] >= 2));
            end
        end
    endtask

    // One update cycle; the model writes the pre-shift column (R7) and shifts history (R6).
    task automatic update(input int row, input bit taken, input bit valid);
        @(negedge clk);
        step_lfsr();
        upd_pc = {lfsr[PC_W-1:ROW_W], 3'(row)};
        upd_taken = taken;
        upd_valid = valid;
        @(posedge clk);
        #0.5;
        upd_valid = 1'b0;
        upd_taken = ~taken;
        if (valid) begin
            if (taken && m_ctr[row][m_hist] < 3) m_ctr[row][m_hist]++;
            if (!taken && m_ctr[row][m_hist] > 0) m_ctr[row][m_hist]--;
            m_hist = ((m_hist << 1) | int'(taken)) & (COLS - 1);
        end
    endtask

    initial begin : watchdog
        #(4.0 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        model_reset();
        // R4: updates presented during reset are discarded.
        for (int i = 0; i < 4; i++) update(5, 1'b1, 1'b1);
        model_reset();
        sweep("R4");
        @(negedge clk);
        rst_n = 1'b1;
        sweep("R4");

        // R1 and R3: repeated taken on one row walks up and saturates.
        for (int i = 0; i < 6; i++) begin
            update(5, 1'b1, 1'b1);
            sweep("R1 R3");
        end
        // R2: repeated not taken walks down and saturates.
        for (int i = 0; i < 7; i++) begin
            update(5, 1'b0, 1'b1);
            sweep("R2");
        end
        // R9: taken run on row 2 leaves other rows untouched.
        for (int i = 0; i < 4; i++) begin
            update(2, 1'b1, 1'b1);
            sweep("R9");
        end
        // R8: invalid updates change nothing.
        for (int i = 0; i < 6; i++) begin
            update(2, 1'b0, 1'b0);
            sweep("R8");
        end
        // Mixed pattern through one row, then across all rows (R5, R6, R7).
        for (int i = 0; i < 120; i++) begin
            step_lfsr();
            update(3, lfsr[4] | lfsr[9], 1'b1);
            sweep("R6 R7");
        end
        for (int i = 0; i < 400; i++) begin
            step_lfsr();
            update(int'(lfsr[6:4]), lfsr[11] ^ lfsr[2], lfsr[17] | lfsr[3]);
            sweep("R5 R6 R7");
        end
        // Reset mid-run restores the initial state (R4).
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #0.5;
        model_reset();
        sweep("R4");
        rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule